// File: doc/BRIEF.md
# Deferred Condition-Code Evaluator

This block keeps processor condition flags in deferred form. An execution unit does not compute the extend, negative, zero, overflow and carry flags after each operation. It stores an operation tag and five 32-bit words instead. The block rebuilds the missing operand from that stored state and produces the true five-bit flag value only when a read asks for it.

The tag names flags-in-place, add, subtract or compare at byte, halfword or word size, or a logic operation. Software-style flag loads use a write port, which turns an explicit five-bit value into the stored flags-in-place form. A flush input turns whatever is stored into the same flags-in-place form in one clock. The stored state is visible on output ports, so the execution unit can save it and restore it.

Top module: `lazy_ccr`

## Requirements
- R1: After reset, the stored tag is 0 (flags-in-place), the Z word is 1 and every other word is 0, so a read returns 5'b00000 and `rd_valid` is low.
- R2: The read value packs X at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. With tag 0 (flags-in-place), X is bit 0 of the X word, N is bit 31 of the N word, Z is 1 exactly when the Z word is zero, V is bit 31 of the V word and C is bit 0 of the C word.
- R3: Add tags are 1 (byte), 2 (halfword) and 3 (word). The N word is the result and the V word is operand 2. Operand 1 is (result − operand 2) sign-extended from bit 7, bit 15 or not at all. V is bit 31 of (result ^ op1) & ~(op1 ^ op2). C and X come from bit 0 of the X word. N and Z are taken from the result.
- R4: Subtract tags are 4, 5 and 6, with sizes in that same order. Operand 1 is (result + operand 2) sign-extended. V is bit 31 of (result ^ op1) & (op1 ^ op2). C and X come from bit 0 of the X word. N and Z are taken from the result.
- R5: Compare tags are 7, 8 and 9. The N word is op1 and the V word is op2. The difference op1 − op2 is sign-extended and supplies N and Z. V is bit 31 of (diff ^ op1) & (op1 ^ op2). C is the unsigned comparison op1 < op2 on the full 32-bit words. X is bit 0 of the X word.
- R6: Logic tag 10 clears C and V, takes N and Z from the N word, and takes X from the X word.
- R7: A write of flag value F stores tag 0, X word = F[4], N word = all ones when F[3] is set and zero otherwise, Z word = the inverse of F[2], V word = all ones when F[1] is set and zero otherwise, and C word = F[0]. A later read returns F.
- R8: A flush with a legal tag stores the currently evaluated flags in the R7 form. A flush with an illegal tag leaves the state unchanged.
- R9: A load stores the tag and all five words as given. When several updates arrive in the same cycle, a write wins over a load, and a load wins over a flush.
- R10: Tags 11 to 15 are illegal. A read of such a state returns flags 5'b00000 with `rd_err` high. For legal tags, `rd_err` is low.
- R11: `rd_valid`, `rd_ccr` and `rd_err` are registered one cycle after `rd_req`. They reflect the state before any update made in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load deferred state |
| ld_tag | input | 4 | Operation tag to load |
| ld_x | input | 32 | X word to load |
| ld_n | input | 32 | N word to load (result or op1) |
| ld_z | input | 32 | Z word to load |
| ld_v | input | 32 | V word to load (op2) |
| ld_c | input | 32 | C word to load |
| wr_en | input | 1 | Explicit flag write |
| wr_ccr | input | 5 | Flag value to write |
| flush_en | input | 1 | Convert state to flags-in-place form |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read response valid |
| rd_ccr | output | 5 | Evaluated flags |
| rd_err | output | 1 | Stored tag was illegal |
| q_tag | output | 4 | Stored tag |
| q_x | output | 32 | Stored X word |
| q_n | output | 32 | Stored N word |
| q_z | output | 32 | Stored Z word |
| q_v | output | 32 | Stored V word |
| q_c | output | 32 | Stored C word |

## Verification
The hardest cases to reach come from sign extension. The recovered operand differs from the stored words only when a byte or halfword result crosses bit 7 or bit 15. Compares also diverge when the unsigned order of the full words disagrees with the signed narrow difference. The stimulus therefore draws words from a pool of edge values (0x7F, 0x80, 0x7FFF, 0x8000, 0x7FFFFFFF, 0x80000000, all ones, zero) and mixes them with random words. It also often fires write, load, flush and read in the same cycle, and includes illegal tags, so both the priority order and the refused flush occur many times.

// File: rtl/lazy_ccr_pkg.sv
package lazy_ccr_pkg;
  localparam int TAG_W = 4;
  localparam int CCR_W = 5;

  // flag bit positions inside the packed value
  localparam int CCR_X = 4;
  localparam int CCR_N = 3;
  localparam int CCR_Z = 2;
  localparam int CCR_V = 1;
  localparam int CCR_C = 0;

  typedef enum logic [TAG_W-1:0] {
    TAG_FLAGS = 4'd0,
    TAG_ADD_B = 4'd1, TAG_ADD_H = 4'd2, TAG_ADD_W = 4'd3,
    TAG_SUB_B = 4'd4, TAG_SUB_H = 4'd5, TAG_SUB_W = 4'd6,
    TAG_CMP_B = 4'd7, TAG_CMP_H = 4'd8, TAG_CMP_W = 4'd9,
    TAG_LOGIC = 4'd10
  } tag_e;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} size_e;

  typedef enum logic [2:0] {
    CLS_FLAGS, CLS_ADD, CLS_SUB, CLS_CMP, CLS_LOGIC, CLS_BAD
  } opcls_e;
endpackage

// File: rtl/lazy_ccr_sext.sv
module lazy_ccr_sext
  import lazy_ccr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [DW-1:0] a_i,
  input  size_e         sz_i,
  output logic [DW-1:0] y_o
);
  localparam int BPAD = DW - BYTE_W;
  localparam int HPAD = DW - HALF_W;

  always_comb begin
    unique case (sz_i)
      SZ_B:    y_o = {{BPAD{a_i[BYTE_W-1]}}, a_i[BYTE_W-1:0]};
      SZ_H:    y_o = {{HPAD{a_i[HALF_W-1]}}, a_i[HALF_W-1:0]};
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/lazy_ccr_eval.sv
module lazy_ccr_eval
  import lazy_ccr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic [DW-1:0]    x_i,
  input  logic [DW-1:0]    n_i,
  input  logic [DW-1:0]    z_i,
  input  logic [DW-1:0]    v_i,
  input  logic [DW-1:0]    c_i,
  output logic [CCR_W-1:0] ccr_o,
  output logic             bad_o
);
  opcls_e        cls;
  size_e         sz;
  logic [DW-1:0] raw, ext;
  logic [DW-1:0] nw, zw, vw;
  logic          cf;

  // decode tag into class and operand size
  always_comb begin
    cls = CLS_BAD;
    sz  = SZ_W;
    unique case (tag_i)
      TAG_FLAGS: cls = CLS_FLAGS;
      TAG_ADD_B: begin cls = CLS_ADD; sz = SZ_B; end
      TAG_ADD_H: begin cls = CLS_ADD; sz = SZ_H; end
      TAG_ADD_W: begin cls = CLS_ADD; sz = SZ_W; end
      TAG_SUB_B: begin cls = CLS_SUB; sz = SZ_B; end
      TAG_SUB_H: begin cls = CLS_SUB; sz = SZ_H; end
      TAG_SUB_W: begin cls = CLS_SUB; sz = SZ_W; end
      TAG_CMP_B: begin cls = CLS_CMP; sz = SZ_B; end
      TAG_CMP_H: begin cls = CLS_CMP; sz = SZ_H; end
      TAG_CMP_W: begin cls = CLS_CMP; sz = SZ_W; end
      TAG_LOGIC: cls = CLS_LOGIC;
      default:   cls = CLS_BAD;
    endcase
  end

  // one shared adder: subtract recovers op1 for add and forms the compare difference
  assign raw = (cls == CLS_SUB) ? (n_i + v_i) : (n_i - v_i);

  lazy_ccr_sext #(.DW(DW), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_sext (
    .a_i  (raw),
    .sz_i (sz),
    .y_o  (ext)
  );

  always_comb begin
    nw = n_i;
    zw = z_i;
    vw = v_i;
    cf = c_i[0];
    unique case (cls)
      CLS_ADD: begin
        zw = n_i;
        vw = (n_i ^ ext) & ~(ext ^ v_i);
        cf = x_i[0];
      end
      CLS_SUB: begin
        zw = n_i;
        vw = (n_i ^ ext) & (ext ^ v_i);
        cf = x_i[0];
      end
      CLS_CMP: begin
        nw = ext;
        zw = ext;
        vw = (ext ^ n_i) & (n_i ^ v_i);
        cf = (n_i < v_i);
      end
      CLS_LOGIC: begin
        zw = n_i;
        vw = '0;
        cf = 1'b0;
      end
      default: ;
    endcase
  end

  assign bad_o = (cls == CLS_BAD);

  always_comb begin
    ccr_o = '0;
    if (!bad_o) begin
      ccr_o[CCR_X] = x_i[0];
      ccr_o[CCR_N] = nw[DW-1];
      ccr_o[CCR_Z] = (zw == '0);
      ccr_o[CCR_V] = vw[DW-1];
      ccr_o[CCR_C] = cf;
    end
  end
endmodule

// File: rtl/lazy_ccr_store.sv
module lazy_ccr_store
  import lazy_ccr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CCR_W-1:0] wr_ccr,
  input  logic             ld_en,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [DW-1:0]    ld_x,
  input  logic [DW-1:0]    ld_n,
  input  logic [DW-1:0]    ld_z,
  input  logic [DW-1:0]    ld_v,
  input  logic [DW-1:0]    ld_c,
  input  logic             fl_en,
  input  logic             fl_ok,
  input  logic [CCR_W-1:0] fl_ccr,
  output logic [TAG_W-1:0] tag_q,
  output logic [DW-1:0]    x_q,
  output logic [DW-1:0]    n_q,
  output logic [DW-1:0]    z_q,
  output logic [DW-1:0]    v_q,
  output logic [DW-1:0]    c_q
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic             upd;
  logic [CCR_W-1:0] src_ccr;
  logic             use_ccr;
  logic [TAG_W-1:0] tag_d;
  logic [DW-1:0]    x_d, n_d, z_d, v_d, c_d;

  // priority: write, then load, then flush
  always_comb begin
    use_ccr = wr_en | (!ld_en & fl_en & fl_ok);
    src_ccr = wr_en ? wr_ccr : fl_ccr;
    upd     = wr_en | ld_en | (fl_en & fl_ok);
    if (use_ccr) begin
      tag_d = TAG_FLAGS;
      x_d   = src_ccr[CCR_X] ? ONE : '0;
      n_d   = {DW{src_ccr[CCR_N]}};
      z_d   = src_ccr[CCR_Z] ? '0 : ONE;
      v_d   = {DW{src_ccr[CCR_V]}};
      c_d   = src_ccr[CCR_C] ? ONE : '0;
    end else begin
      tag_d = ld_tag;
      x_d   = ld_x;
      n_d   = ld_n;
      z_d   = ld_z;
      v_d   = ld_v;
      c_d   = ld_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= TAG_FLAGS;
      x_q   <= '0;
      n_q   <= '0;
      z_q   <= ONE;
      v_q   <= '0;
      c_q   <= '0;
    end else if (upd) begin
      tag_q <= tag_d;
      x_q   <= x_d;
      n_q   <= n_d;
      z_q   <= z_d;
      v_q   <= v_d;
      c_q   <= c_d;
    end
  end

  assert_wr_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tag_q == TAG_FLAGS));
  assert_wr_nword_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((n_q == '0) || (n_q == {DW{1'b1}})));
  assert_ld_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !wr_en) |=> (tag_q == $past(ld_tag) && n_q == $past(ld_n)));
  assert_fl_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !fl_ok && !wr_en && !ld_en) |=> $stable(tag_q) && $stable(n_q));
endmodule

// File: rtl/lazy_ccr.sv
module lazy_ccr
  import lazy_ccr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [3:0]    ld_tag,
  input  logic [DW-1:0] ld_x,
  input  logic [DW-1:0] ld_n,
  input  logic [DW-1:0] ld_z,
  input  logic [DW-1:0] ld_v,
  input  logic [DW-1:0] ld_c,
  input  logic          wr_en,
  input  logic [4:0]    wr_ccr,
  input  logic          flush_en,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [4:0]    rd_ccr,
  output logic          rd_err,
  output logic [3:0]    q_tag,
  output logic [DW-1:0] q_x,
  output logic [DW-1:0] q_n,
  output logic [DW-1:0] q_z,
  output logic [DW-1:0] q_v,
  output logic [DW-1:0] q_c
);
  logic [1:0]       rst_sync;
  logic             rst_s;
  logic [CCR_W-1:0] cur_ccr;
  logic             cur_bad;
  logic             rd_valid_d;
  logic [CCR_W-1:0] rd_ccr_d;
  logic             rd_err_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  lazy_ccr_eval #(.DW(DW), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_eval (
    .tag_i (q_tag),
    .x_i   (q_x),
    .n_i   (q_n),
    .z_i   (q_z),
    .v_i   (q_v),
    .c_i   (q_c),
    .ccr_o (cur_ccr),
    .bad_o (cur_bad)
  );

  lazy_ccr_store #(.DW(DW)) u_store (
    .clk    (clk),
    .rst_n  (rst_s),
    .wr_en  (wr_en),
    .wr_ccr (wr_ccr),
    .ld_en  (ld_en),
    .ld_tag (ld_tag),
    .ld_x   (ld_x),
    .ld_n   (ld_n),
    .ld_z   (ld_z),
    .ld_v   (ld_v),
    .ld_c   (ld_c),
    .fl_en  (flush_en),
    .fl_ok  (!cur_bad),
    .fl_ccr (cur_ccr),
    .tag_q  (q_tag),
    .x_q    (q_x),
    .n_q    (q_n),
    .z_q    (q_z),
    .v_q    (q_v),
    .c_q    (q_c)
  );

  // read response next-state
  always_comb begin
    rd_valid_d = rd_req;
    rd_ccr_d   = rd_req ? cur_ccr : rd_ccr;
    rd_err_d   = rd_req ? cur_bad : rd_err;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rd_valid <= 1'b0;
      rd_ccr   <= '0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd_valid_d;
      rd_ccr   <= rd_ccr_d;
      rd_err   <= rd_err_d;
    end
  end

  assert_rd_valid_R11: assert property (@(posedge clk) disable iff (!rst_s)
    rd_req |=> rd_valid);
  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_s)
    !rd_req |=> !rd_valid);
  assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_s)
    rd_err |-> (rd_ccr == '0));
  assert_logic_clear_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_req && q_tag == TAG_LOGIC) |=> (rd_ccr[CCR_V] == 1'b0 && rd_ccr[CCR_C] == 1'b0));
  assert_flush_keeps_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (flush_en && !wr_en && !ld_en && !cur_bad) |=> (cur_ccr == $past(cur_ccr)));
endmodule

// File: tb/lazy_ccr_test.sv
module lazy_ccr_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en, wr_en, flush_en, rd_req;
  logic [3:0]  ld_tag;
  logic [31:0] ld_x, ld_n, ld_z, ld_v, ld_c;
  logic [4:0]  wr_ccr;
  logic        rd_valid, rd_err;
  logic [4:0]  rd_ccr;
  logic [3:0]  q_tag;
  logic [31:0] q_x, q_n, q_z, q_v, q_c;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [3:0]  m_tag;
  logic [31:0] m_x, m_n, m_z, m_v, m_c;

  always #(PERIOD/2) clk = ~clk;

  lazy_ccr uut (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_tag(ld_tag), .ld_x(ld_x), .ld_n(ld_n), .ld_z(ld_z),
    .ld_v(ld_v), .ld_c(ld_c), .wr_en(wr_en), .wr_ccr(wr_ccr),
    .flush_en(flush_en), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_ccr(rd_ccr), .rd_err(rd_err),
    .q_tag(q_tag), .q_x(q_x), .q_n(q_n), .q_z(q_z), .q_v(q_v), .q_c(q_c)
  );

  task automatic check(input string req, input logic [199:0] act, input logic [199:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [31:0] a, input int sz);
    if (sz == 0) return 32'(signed'(a[7:0]));
    if (sz == 1) return 32'(signed'(a[15:0]));
    return a;
  endfunction

  // returns {err, X, N, Z, V, C}
  function automatic logic [5:0] ref_eval(input logic [3:0] t, input logic [31:0] x, n, z, v, c);
    logic [31:0] op1, diff, ov;
    int sz;
    if (t == 0)  return {1'b0, x[0], n[31], z == 0, v[31], c[0]};
    if (t == 10) return {1'b0, x[0], n[31], n == 0, 1'b0, 1'b0};
    if (t > 10)  return 6'b100000;
    sz = (int'(t) - 1) % 3;
    case ((int'(t) - 1) / 3)
      0: begin op1 = sx(n - v, sz); ov = (n ^ op1) & ~(op1 ^ v);
               return {1'b0, x[0], n[31], n == 0, ov[31], x[0]}; end
      1: begin op1 = sx(n + v, sz); ov = (n ^ op1) & (op1 ^ v);
               return {1'b0, x[0], n[31], n == 0, ov[31], x[0]}; end
      default: begin diff = sx(n - v, sz); ov = (diff ^ n) & (n ^ v);
               return {1'b0, x[0], diff[31], diff == 0, ov[31], n < v}; end
    endcase
  endfunction

  function automatic string tag_req(input logic [3:0] t);
    if (t == 0) return "R2";
    if (t <= 3) return "R3";
    if (t <= 6) return "R4";
    if (t <= 9) return "R5";
    if (t == 10) return "R6";
    return "R10";
  endfunction

  task automatic model_put_flags(input logic [4:0] f);
    m_tag = 4'd0;
    m_x = {31'b0, f[4]};
    m_n = {32{f[3]}};
    m_z = {31'b0, ~f[2]};
    m_v = {32{f[1]}};
    m_c = {31'b0, f[0]};
  endtask

  // one clock: drive at negedge, compare shortly after the posedge
  task automatic step(input logic iwr, input logic [4:0] iccr, input logic ild,
                      input logic [3:0] itag, input logic [31:0] ix, in_, iz, iv, ic,
                      input logic ifl, input logic ird);
    logic [5:0] e;
    string rl, ql;
    wr_en = iwr; wr_ccr = iccr; ld_en = ild; ld_tag = itag;
    ld_x = ix; ld_n = in_; ld_z = iz; ld_v = iv; ld_c = ic;
    flush_en = ifl; rd_req = ird;
    e  = ref_eval(m_tag, m_x, m_n, m_z, m_v, m_c);
    rl = tag_req(m_tag);
    ql = "R9";
    if (iwr) begin model_put_flags(iccr); ql = "R7"; end
    else if (ild) begin
      m_tag = itag; m_x = ix; m_n = in_; m_z = iz; m_v = iv; m_c = ic;
    end else if (ifl) begin
      ql = "R8";
      if (!e[5]) model_put_flags(e[4:0]);
    end
    @(posedge clk);
    #1;
    check("R11 valid", 200'(rd_valid), 200'(ird));
    if (ird) check(rl, 200'({rd_err, rd_ccr}), 200'(e));
    check(ql, {q_tag, q_x, q_n, q_z, q_v, q_c}, {m_tag, m_x, m_n, m_z, m_v, m_c});
    @(negedge clk);
  endtask

  task automatic idle_read();
    step(1'b0, 5'd0, 1'b0, 4'd0, 0, 0, 0, 0, 0, 1'b0, 1'b1);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 9))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7F;
      3: return 32'h80;
      4: return 32'h7FFF;
      5: return 32'h8000;
      6: return 32'h7FFF_FFFF;
      7: return 32'h8000_0000;
      8: return 32'(signed'(8'($urandom)));
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_en = 0; wr_ccr = 0; ld_en = 0; ld_tag = 0; flush_en = 0; rd_req = 0;
    ld_x = 0; ld_n = 0; ld_z = 0; ld_v = 0; ld_c = 0;
    m_tag = 0; m_x = 0; m_n = 0; m_z = 32'd1; m_v = 0; m_c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 state", {q_tag, q_x, q_n, q_z, q_v, q_c}, {4'd0, 32'd0, 32'd0, 32'd1, 32'd0, 32'd0});
    check("R1 valid", 200'(rd_valid), 200'(0));
    idle_read();
    check("R1 read", 200'({rd_err, rd_ccr}), 200'(0));

    // R7: explicit write and readback
    step(1'b1, 5'b10101, 1'b0, 4'd0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
    idle_read();
    check("R7 readback", 200'(rd_ccr), 200'(5'b10101));

    // R3: byte add 0x7F + 1 overflows to 0x80
    step(1'b0, 0, 1'b1, 4'd1, 32'd0, 32'hFFFF_FF80, 32'd0, 32'd1, 32'd0, 1'b0, 1'b0);
    idle_read();
    check("R3 byte add", 200'(rd_ccr), 200'(5'h0A));

    // R8: flush that state and read again
    step(1'b0, 0, 1'b0, 4'd0, 0, 0, 0, 0, 0, 1'b1, 1'b0);
    check("R8 tag", 200'(q_tag), 200'(0));
    idle_read();
    check("R8 read", 200'(rd_ccr), 200'(5'h0A));

    // R5: word compare 1 vs 2
    step(1'b0, 0, 1'b1, 4'd9, 32'd1, 32'd1, 32'd0, 32'd2, 32'd0, 1'b0, 1'b0);
    idle_read();
    check("R5 cmp", 200'(rd_ccr), 200'(5'h19));

    // R10: illegal tag read and refused flush
    step(1'b0, 0, 1'b1, 4'd13, 32'd1, 32'd5, 32'd7, 32'd9, 32'd1, 1'b0, 1'b0);
    idle_read();
    check("R10 err", 200'({rd_err, rd_ccr}), 200'(6'b100000));
    step(1'b0, 0, 1'b0, 4'd0, 0, 0, 0, 0, 0, 1'b1, 1'b0);
    check("R10 flush refused", 200'(q_tag), 200'(13));

    // R9: write beats load in the same cycle
    step(1'b1, 5'b01000, 1'b1, 4'd3, 32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 1'b1, 1'b1);
    check("R9 priority", 200'(q_n), 200'(32'hFFFF_FFFF));

    // mixed random traffic checked against the model every clock
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] t;
      t = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(11, 15)) : 4'($urandom_range(0, 10));
      step($urandom_range(0, 5) == 0, 5'($urandom), $urandom_range(0, 1) == 1, t,
           pick(), pick(), pick(), pick(), pick(),
           $urandom_range(0, 3) == 0, $urandom_range(0, 2) != 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule